// File: doc/BRIEF.md
# Decode-Once Pipeline Control Sequencer

This block turns the opcode and function fields of the instruction sitting in the decode stage of a five-stage integer pipeline into a bundle of control signals. It decodes each instruction once. It then moves that bundle forward one stage per clock, next to the instruction it belongs to. Each stage register keeps only the fields that its own stage or a later stage still needs, so the bundle gets narrower as it moves. The execute group is dropped after execute, and the memory group is dropped after the memory stage.

Each stage register has a valid bit. The instruction in decode enters the execute register only when it is valid and no bubble or hold is requested. In every other case an all-zero, invalid bundle enters instead. A hold keeps the decode instruction where it is, so the front of the pipe can present it again on a later cycle. The stages behind execute keep moving during a hold, so older instructions drain normally.

Top module: `pipe_ctrl_unit`

## Requirements
- R1: A synchronous active-high reset clears all outputs to zero. The first edge without reset then loads the execute register from the decode inputs.
- R2: An instruction issued at one rising edge shows its execute group on the ex_* outputs right after that edge. The execute group is ex_valid, ex_ext_sign, ex_alu_op, ex_dst_rd and ex_src_imm.
- R3: The memory group (mem_valid, mem_branch, mem_store) of an issued instruction appears one edge after its execute group.
- R4: The write-back group (wb_valid, wb_from_mem, wb_reg_write) of an issued instruction appears two edges after its execute group.
- R5: Opcodes: 0x00 is register-register, 0x08 is add-immediate, 0x0D is or-immediate, 0x23 is load, 0x2B is store and 0x04 is branch-if-equal. ex_ext_sign is 1 for add-immediate, load, store and branch. It is 0 for or-immediate and register-register.
- R6: ex_dst_rd is 1 for register-register (the rd field is the target) and 0 for the immediate forms (the rt field is the target). ex_src_imm is 1 for add-immediate, or-immediate, load and store.
- R7: ex_alu_op is 0 for add, 1 for subtract, 2 for and, 3 for or and 4 for set-less-than. Register-register functions map 0x20 to add, 0x22 to subtract, 0x24 to and, 0x25 to or and 0x2A to set-less-than. Add-immediate, load and store use add, or-immediate uses or, and branch uses subtract.
- R8: bubble_req at an edge puts an invalid, all-zero bundle into the execute register. That bundle then shows as invalid with zero controls at the memory stage and then at write-back.
- R9: hold_req at an edge keeps the decode instruction out of the execute register, which becomes invalid. The memory and write-back registers still advance.
- R10: dec_valid low at an edge gives an invalid execute bundle, as a bubble does.
- R11: wb_reg_write is 1 only for a valid register-register instruction with a known function, add-immediate, or-immediate or load. wb_from_mem is 1 only for load. mem_store is 1 only for store and mem_branch only for branch.
- R12: An unknown opcode, or a register-register instruction with an unknown function, gives a valid bundle whose control fields are all zero. Such a bundle never writes a register or memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_opcode | input | 6 | Opcode field of the instruction in decode |
| dec_funct | input | 6 | Function field of the instruction in decode |
| dec_valid | input | 1 | Decode slot holds a real instruction |
| bubble_req | input | 1 | Insert an empty slot into execute |
| hold_req | input | 1 | Stall decode; do not issue this cycle |
| ex_valid | output | 1 | Execute slot is valid |
| ex_ext_sign | output | 1 | 1 = sign-extend immediate, 0 = zero-extend |
| ex_alu_op | output | 3 | ALU operation code |
| ex_dst_rd | output | 1 | 1 = write rd, 0 = write rt |
| ex_src_imm | output | 1 | 1 = ALU second operand is the immediate |
| mem_valid | output | 1 | Memory slot is valid |
| mem_branch | output | 1 | Branch-if-equal in memory stage |
| mem_store | output | 1 | Memory write enable |
| wb_valid | output | 1 | Write-back slot is valid |
| wb_from_mem | output | 1 | 1 = write-back data comes from memory |
| wb_reg_write | output | 1 | Register write enable |

## Verification
A fault in the decoder appears on the ex_* outputs one edge after issue. It then shows again, with a delay, on the store, branch and register-write enables. A slip in the stage registers makes a control group line up with the wrong instruction. That shows as a mismatch at the memory outputs one edge later and at the write-back outputs two edges later. A hold or bubble that is not applied lets a stale or duplicate bundle through, which then raises a write enable one or two edges later. The bench keeps its own three-slot model of the pipe and compares every output group on every cycle, so each of these faults is caught within three cycles.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  localparam int OPC_W = 6;
  localparam int FN_W  = 6;
  localparam int ALU_W = 3;

  localparam logic [OPC_W-1:0] OP_RTYPE = 6'h00;
  localparam logic [OPC_W-1:0] OP_BEQ   = 6'h04;
  localparam logic [OPC_W-1:0] OP_ADDI  = 6'h08;
  localparam logic [OPC_W-1:0] OP_ORI   = 6'h0D;
  localparam logic [OPC_W-1:0] OP_LOAD  = 6'h23;
  localparam logic [OPC_W-1:0] OP_STORE = 6'h2B;

  localparam logic [FN_W-1:0] FN_ADD = 6'h20;
  localparam logic [FN_W-1:0] FN_SUB = 6'h22;
  localparam logic [FN_W-1:0] FN_AND = 6'h24;
  localparam logic [FN_W-1:0] FN_OR  = 6'h25;
  localparam logic [FN_W-1:0] FN_SLT = 6'h2A;

  typedef enum logic [ALU_W-1:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_SLT = 3'd4
  } alu_op_e;

  typedef struct packed {
    logic    ext_sign;
    alu_op_e alu_op;
    logic    dst_rd;
    logic    src_imm;
  } ex_ctl_t;

  typedef struct packed {
    logic branch;
    logic store;
  } mem_ctl_t;

  typedef struct packed {
    logic from_mem;
    logic reg_write;
  } wb_ctl_t;

  typedef struct packed {
    ex_ctl_t  ex;
    mem_ctl_t mem;
    wb_ctl_t  wb;
  } bundle_t;

  localparam int EX_W  = $bits(ex_ctl_t);
  localparam int MEM_W = $bits(mem_ctl_t);
  localparam int WB_W  = $bits(wb_ctl_t);
  localparam int BUNDLE_W = $bits(bundle_t);
endpackage

// File: rtl/pcu_main_decoder.sv
module pcu_main_decoder
  import pcu_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic [FN_W-1:0]  funct,
  output bundle_t          ctl
);
  alu_op_e r_op;
  logic    r_known;

  // Function-field decode for register-register instructions.
  always_comb begin
    r_known = 1'b1;
    r_op    = ALU_ADD;
    unique case (funct)
      FN_ADD:  r_op = ALU_ADD;
      FN_SUB:  r_op = ALU_SUB;
      FN_AND:  r_op = ALU_AND;
      FN_OR:   r_op = ALU_OR;
      FN_SLT:  r_op = ALU_SLT;
      default: r_known = 1'b0;
    endcase
  end

  always_comb begin
    ctl = '0;
    unique case (opcode)
      OP_RTYPE: begin
        if (r_known) begin
          ctl.ex.alu_op     = r_op;
          ctl.ex.dst_rd     = 1'b1;
          ctl.wb.reg_write  = 1'b1;
        end
      end
      OP_ADDI: begin
        ctl.ex.ext_sign   = 1'b1;
        ctl.ex.alu_op     = ALU_ADD;
        ctl.ex.src_imm    = 1'b1;
        ctl.wb.reg_write  = 1'b1;
      end
      OP_ORI: begin
        ctl.ex.alu_op     = ALU_OR;
        ctl.ex.src_imm    = 1'b1;
        ctl.wb.reg_write  = 1'b1;
      end
      OP_LOAD: begin
        ctl.ex.ext_sign   = 1'b1;
        ctl.ex.alu_op     = ALU_ADD;
        ctl.ex.src_imm    = 1'b1;
        ctl.wb.from_mem   = 1'b1;
        ctl.wb.reg_write  = 1'b1;
      end
      OP_STORE: begin
        ctl.ex.ext_sign   = 1'b1;
        ctl.ex.alu_op     = ALU_ADD;
        ctl.ex.src_imm    = 1'b1;
        ctl.mem.store     = 1'b1;
      end
      OP_BEQ: begin
        ctl.ex.ext_sign   = 1'b1;
        ctl.ex.alu_op     = ALU_SUB;
        ctl.mem.branch    = 1'b1;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/pcu_stage_reg.sv
module pcu_stage_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         squash,
  input  logic         d_valid,
  input  logic [W-1:0] d,
  output logic         q_valid,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || squash) begin
      q_valid <= 1'b0;
      q       <= '0;
    end else begin
      q_valid <= d_valid;
      q       <= d_valid ? d : '0;
    end
  end
endmodule

// File: rtl/pipe_ctrl_unit.sv
module pipe_ctrl_unit
  import pcu_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] dec_opcode,
  input  logic [FN_W-1:0]  dec_funct,
  input  logic             dec_valid,
  input  logic             bubble_req,
  input  logic             hold_req,
  output logic             ex_valid,
  output logic             ex_ext_sign,
  output logic [ALU_W-1:0] ex_alu_op,
  output logic             ex_dst_rd,
  output logic             ex_src_imm,
  output logic             mem_valid,
  output logic             mem_branch,
  output logic             mem_store,
  output logic             wb_valid,
  output logic             wb_from_mem,
  output logic             wb_reg_write
);
  localparam int EXR_W  = BUNDLE_W;
  localparam int MEMR_W = MEM_W + WB_W;

  bundle_t dec_ctl;
  logic    issue;

  pcu_main_decoder u_dec (
    .opcode (dec_opcode),
    .funct  (dec_funct),
    .ctl    (dec_ctl)
  );

  assign issue = dec_valid & ~bubble_req & ~hold_req;

  // Execute register: full bundle.
  logic [EXR_W-1:0] ex_q_raw;
  bundle_t          ex_q;
  logic             ex_v;

  pcu_stage_reg #(.W(EXR_W)) u_ex (
    .clk     (clk),
    .rst     (rst),
    .squash  (~issue),
    .d_valid (dec_valid),
    .d       (dec_ctl),
    .q_valid (ex_v),
    .q       (ex_q_raw)
  );
  assign ex_q = bundle_t'(ex_q_raw);

  // Memory register: execute group dropped.
  logic [MEMR_W-1:0] mem_q_raw;
  mem_ctl_t          mem_q;
  wb_ctl_t           mem_wb_q;
  logic              mem_v;

  pcu_stage_reg #(.W(MEMR_W)) u_mem (
    .clk     (clk),
    .rst     (rst),
    .squash  (1'b0),
    .d_valid (ex_v),
    .d       ({ex_q.mem, ex_q.wb}),
    .q_valid (mem_v),
    .q       (mem_q_raw)
  );
  assign {mem_q, mem_wb_q} = mem_q_raw;

  // Write-back register: only the write-back group remains.
  logic [WB_W-1:0] wb_q_raw;
  wb_ctl_t         wb_q;
  logic            wb_v;

  pcu_stage_reg #(.W(WB_W)) u_wb (
    .clk     (clk),
    .rst     (rst),
    .squash  (1'b0),
    .d_valid (mem_v),
    .d       (mem_wb_q),
    .q_valid (wb_v),
    .q       (wb_q_raw)
  );
  assign wb_q = wb_ctl_t'(wb_q_raw);

  assign ex_valid     = ex_v;
  assign ex_ext_sign  = ex_q.ex.ext_sign;
  assign ex_alu_op    = ex_q.ex.alu_op;
  assign ex_dst_rd    = ex_q.ex.dst_rd;
  assign ex_src_imm   = ex_q.ex.src_imm;
  assign mem_valid    = mem_v;
  assign mem_branch   = mem_v & mem_q.branch;
  assign mem_store    = mem_v & mem_q.store;
  assign wb_valid     = wb_v;
  assign wb_from_mem  = wb_v & wb_q.from_mem;
  assign wb_reg_write = wb_v & wb_q.reg_write;
endmodule

// File: rtl/pcu_checker.sv
module pcu_checker
  import pcu_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [OPC_W-1:0] dec_opcode,
  input logic [FN_W-1:0]  dec_funct,
  input logic             dec_valid,
  input logic             bubble_req,
  input logic             hold_req,
  input logic             ex_valid,
  input logic             ex_ext_sign,
  input logic [ALU_W-1:0] ex_alu_op,
  input logic             ex_dst_rd,
  input logic             ex_src_imm,
  input logic             mem_valid,
  input logic             mem_branch,
  input logic             mem_store,
  input logic             wb_valid,
  input logic             wb_from_mem,
  input logic             wb_reg_write
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!ex_valid && !mem_valid && !wb_valid && !wb_reg_write && !mem_store));

  a_r3_mem_follows_ex: assert property (@(posedge clk) disable iff (rst)
    ex_valid |=> mem_valid);

  a_r4_wb_follows_mem: assert property (@(posedge clk) disable iff (rst)
    mem_valid |=> wb_valid);

  a_r8_bubble_empties_ex: assert property (@(posedge clk) disable iff (rst)
    bubble_req |=> (!ex_valid && ex_alu_op == '0 && !ex_src_imm && !ex_dst_rd));

  a_r9_hold_blocks_issue: assert property (@(posedge clk) disable iff (rst)
    hold_req |=> !ex_valid);

  a_r10_no_valid_no_issue: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |=> !ex_valid);

  a_r11_load_writes_from_mem: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !bubble_req && !hold_req && dec_opcode == OP_LOAD)
      |=> ex_src_imm ##2 (wb_from_mem && wb_reg_write));

  a_r11_branch_reaches_mem: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !bubble_req && !hold_req && dec_opcode == OP_BEQ)
      |=> ##1 (mem_branch && !mem_store));

  a_r12_unknown_no_write: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !bubble_req && !hold_req && dec_opcode == 6'h3F)
      |=> ex_valid ##1 (!mem_store && !mem_branch) ##1 !wb_reg_write);
endmodule

bind pipe_ctrl_unit pcu_checker u_chk (.*);

// File: tb/sim_pipe_ctrl_unit.sv
module sim_pipe_ctrl_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic [5:0] dec_opcode;
  logic [5:0] dec_funct;
  logic       dec_valid, bubble_req, hold_req;
  logic       ex_valid, ex_ext_sign, ex_dst_rd, ex_src_imm;
  logic [2:0] ex_alu_op;
  logic       mem_valid, mem_branch, mem_store;
  logic       wb_valid, wb_from_mem, wb_reg_write;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string tag = "R1";

  // Expected slots: {valid, ext, alu[2:0], dst_rd, src_imm, branch, store, from_mem, regw}
  logic [10:0] m1 = '0, m2 = '0, m3 = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pipe_ctrl_unit u0 (.*);

  function automatic logic [10:0] expect_bundle(logic [5:0] op, logic [5:0] fn);
    logic [10:0] b = '0;
    b[10] = 1'b1;
    case (op)
      6'h00: case (fn)
        6'h20: b[9:0] = {1'b0, 3'd0, 1'b1, 1'b0, 2'b00, 2'b01};
        6'h22: b[9:0] = {1'b0, 3'd1, 1'b1, 1'b0, 2'b00, 2'b01};
        6'h24: b[9:0] = {1'b0, 3'd2, 1'b1, 1'b0, 2'b00, 2'b01};
        6'h25: b[9:0] = {1'b0, 3'd3, 1'b1, 1'b0, 2'b00, 2'b01};
        6'h2A: b[9:0] = {1'b0, 3'd4, 1'b1, 1'b0, 2'b00, 2'b01};
        default: b[9:0] = '0;
      endcase
      6'h08: b[9:0] = {1'b1, 3'd0, 1'b0, 1'b1, 2'b00, 2'b01};
      6'h0D: b[9:0] = {1'b0, 3'd3, 1'b0, 1'b1, 2'b00, 2'b01};
      6'h23: b[9:0] = {1'b1, 3'd0, 1'b0, 1'b1, 2'b00, 2'b11};
      6'h2B: b[9:0] = {1'b1, 3'd0, 1'b0, 1'b1, 2'b01, 2'b00};
      6'h04: b[9:0] = {1'b1, 3'd1, 1'b0, 1'b0, 2'b10, 2'b00};
      default: b[9:0] = '0;
    endcase
    return b;
  endfunction

  task automatic check(string what, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s got=%h exp=%h t=%0t", tag, what, got, exp, $time);
    end
  endtask

  // Drive inputs, take one edge, update model, compare at negedge.
  task automatic step(logic r, logic v, logic [5:0] op, logic [5:0] fn, logic bub, logic hld);
    rst = r; dec_valid = v; dec_opcode = op; dec_funct = fn;
    bubble_req = bub; hold_req = hld;
    @(posedge clk);
    if (r) begin
      m1 = '0; m2 = '0; m3 = '0;
    end else begin
      m3 = {m2[10], 8'b0, m2[1:0]};
      m2 = {m1[10], 6'b0, m1[3:0]};
      m1 = (v && !bub && !hld) ? expect_bundle(op, fn) : '0;
    end
    @(negedge clk);
    check("ex (R2 R5 R6 R7)", {1'b0, ex_valid, ex_ext_sign, ex_alu_op, ex_dst_rd, ex_src_imm},
          {1'b0, m1[10:4]});
    check("mem (R3 R11)", {5'b0, mem_valid, mem_branch, mem_store}, {5'b0, m2[10], m2[3:2]});
    check("wb (R4 R11)", {5'b0, wb_valid, wb_from_mem, wb_reg_write}, {5'b0, m3[10], m3[1:0]});
  endtask

  function automatic logic [5:0] pick_op(int u);
    case (u % 8)
      0: return 6'h00; 1: return 6'h08; 2: return 6'h0D; 3: return 6'h23;
      4: return 6'h2B; 5: return 6'h04; 6: return 6'h00;
      default: return 6'($urandom);
    endcase
  endfunction

  function automatic logic [5:0] pick_fn(int u);
    case (u % 6)
      0: return 6'h20; 1: return 6'h22; 2: return 6'h24; 3: return 6'h25;
      4: return 6'h2A; default: return 6'($urandom);
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; dec_valid = 0; dec_opcode = 0; dec_funct = 0; bubble_req = 0; hold_req = 0;
    @(negedge clk);
    tag = "R1";
    step(1, 1, 6'h23, 6'h00, 0, 0);
    step(1, 1, 6'h2B, 6'h00, 0, 0);
    // R1: first edge out of reset issues normally
    step(0, 1, 6'h23, 6'h00, 0, 0);

    tag = "R5";
    step(0, 1, 6'h08, 6'h00, 0, 0);
    step(0, 1, 6'h0D, 6'h00, 0, 0);
    step(0, 1, 6'h2B, 6'h00, 0, 0);
    step(0, 1, 6'h04, 6'h00, 0, 0);
    tag = "R6";
    step(0, 1, 6'h00, 6'h20, 0, 0);
    step(0, 1, 6'h0D, 6'h11, 0, 0);
    tag = "R7";
    step(0, 1, 6'h00, 6'h22, 0, 0);
    step(0, 1, 6'h00, 6'h24, 0, 0);
    step(0, 1, 6'h00, 6'h25, 0, 0);
    step(0, 1, 6'h00, 6'h2A, 0, 0);
    tag = "R8";
    step(0, 1, 6'h23, 6'h00, 1, 0);
    step(0, 1, 6'h08, 6'h00, 0, 0);
    step(0, 1, 6'h2B, 6'h00, 0, 0);
    step(0, 1, 6'h2B, 6'h00, 0, 0);
    tag = "R9";
    step(0, 1, 6'h23, 6'h00, 0, 0);
    step(0, 1, 6'h00, 6'h20, 0, 1);
    step(0, 1, 6'h00, 6'h20, 0, 1);
    step(0, 1, 6'h00, 6'h20, 0, 0);
    tag = "R10";
    step(0, 0, 6'h23, 6'h00, 0, 0);
    step(0, 0, 6'h2B, 6'h00, 0, 0);
    tag = "R12";
    step(0, 1, 6'h3F, 6'h00, 0, 0);
    step(0, 1, 6'h00, 6'h3F, 0, 0);
    step(0, 1, 6'h12, 6'h20, 0, 0);
    step(0, 1, 6'h12, 6'h20, 0, 0);
    step(0, 1, 6'h12, 6'h20, 0, 0);

    tag = "R2 R3 R4 R11";
    for (int i = 0; i < 3000; i++) begin
      int u = int'($urandom);
      step(($urandom % 200) == 0, ($urandom % 8) != 0, pick_op(u), pick_fn(u >> 4),
           ($urandom % 10) == 0, ($urandom % 10) == 0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule